// File: doc/BRIEF.md
# Open-Drain Serial Clock Generator with Wired-AND Synchronization

This block produces the serial clock of a two-wire bus master from a fast system clock. It pulls the clock line low by asserting an output enable, and releases the line by dropping that enable. The line itself is pulled up outside the block, so any device on the bus can hold it low. The block reads the real line level back. It times its released phase only from the cycle in which the line is actually seen high. If another device pulls the line low early, the block cuts its own high phase short and starts a fresh low phase at once. As a result the slowest device on the bus sets the low time, and the first device to finish its high phase sets the falling edge.

The phase lengths come from a period word and two mode bits. In standard mode, and in fast mode with the ratio bit clear, the high and low phases each last one period word of system clocks. In fast mode with the ratio bit set, the high phase lasts nine period words and the low phase lasts sixteen. For example, with a 125 ns system clock and a period word of 40, standard mode gives 5 us high and 5 us low. The byte engine receives two one-cycle strobes from the block: one where it should change the data line, and one where it should sample it.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, and while the run request has never been raised, the drive-low enable `sclOe` (1 = pull the line low) is 0 and both strobes are 0.
- R2: In standard mode (`fastMode`=0), each driven-low phase lasts P system clocks and each line-high phase lasts P clocks, where P is the effective period word. The `fastDuty` bit has no effect in this mode.
- R3: In fast mode with `fastDuty`=0, both phases last P clocks.
- R4: In fast mode with `fastDuty`=1, the driven-low phase lasts 16×P clocks and the line-high phase lasts 9×P clocks.
- R5: The effective period word P is `ccrCfg`, except that any value below 4 is treated as 4.
- R6: When another device holds the line low after `sclOe` drops, the high phase is still a full length. Its first cycle is the first cycle in which `sclIn` reads 1.
- R7: If `sclIn` reads 0 during the block's high phase while running, `sclOe` is 1 in the next cycle, and a full-length low phase follows. A high phase cut short before its midpoint produces no sample strobe.
- R8: `sampleStb` is high for exactly one cycle in each line-high phase, at position H/2 (integer division). H is the high length and position 0 is the first cycle the line reads high. The strobe occurs only while the line reads high.
- R9: `changeStb` is high for exactly one cycle per driven-low phase, in its third cycle (position 2 counting from 0).
- R10: When the run request drops, the block finishes the phase in progress and then leaves `sclOe` at 0. It does not drive the line low again until the request returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| runReq | input | 1 | Keep generating clock periods while high |
| ccrCfg | input | 12 | Period word in system clock cycles |
| fastMode | input | 1 | 0 = standard timing, 1 = fast timing |
| fastDuty | input | 1 | In fast mode, 1 selects the 9:16 high:low ratio |
| sclIn | input | 1 | Synchronized level of the wired clock line |
| sclOe | output | 1 | 1 pulls the clock line low, 0 releases it |
| sampleStb | output | 1 | One-cycle pulse at mid high phase |
| changeStb | output | 1 | One-cycle pulse shortly after the block starts driving low |

## Verification
A wrong phase state or a wrong count shows up at the ports within one clock period: a low run or high run of the wrong length, or a strobe at the wrong position. These are measured run by run against lengths computed from the period word and the mode bits. Clock stretching and early pulls by another device are imitated on the shared line. A state machine that counts during a stretch, or ignores an early pull, therefore gives a wrong high length or a late `sclOe` in the very next cycle. A stuck state after the run request drops shows up as an unexpected drive-low within the following period.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } sclState_t;

  // control to datapath: counter commands
  typedef struct packed {
    logic clr;   // counter to zero
    logic seed;  // counter to one
    logic inc;   // counter plus one
  } cntCtrl_t;

  // datapath to control: counter compare results
  typedef struct packed {
    logic lowDone;
    logic highDone;
    logic atMid;
    logic atChange;
  } cntStat_t;

endpackage

// File: rtl/sclgen_timer.sv
module sclgen_timer
  import sclgen_pkg::*;
#(
  parameter int CCR_W         = 12,
  parameter int CCR_MIN       = 4,
  parameter int CHANGE_AT     = 2,
  parameter bit FAST_RATIO_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CCR_W-1:0] ccrCfg,
  input  logic             fastMode,
  input  logic             fastDuty,
  input  cntCtrl_t         ctrl,
  output cntStat_t         stat
);

  localparam int CNT_W = CCR_W + 5;

  logic [CNT_W-1:0] ccrEff;
  logic [CNT_W-1:0] lowLen;
  logic [CNT_W-1:0] highLen;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    if (ccrCfg < CCR_W'(CCR_MIN)) ccrEff = CNT_W'(CCR_MIN);
    else                          ccrEff = CNT_W'(ccrCfg);
  end

  generate
    if (FAST_RATIO_EN) begin : g_ratio
      logic useRatio;
      assign useRatio = fastMode & fastDuty;
      assign lowLen   = useRatio ? (ccrEff << 4) : ccrEff;
      assign highLen  = useRatio ? ((ccrEff << 3) + ccrEff) : ccrEff;
    end else begin : g_plain
      logic unusedBits;
      assign unusedBits = fastMode ^ fastDuty;
      assign lowLen     = ccrEff;
      assign highLen    = ccrEff;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= '0;
    else if (ctrl.clr)  cnt <= '0;
    else if (ctrl.seed) cnt <= CNT_W'(1);
    else if (ctrl.inc)  cnt <= cnt + 1'b1;
  end

  always_comb begin
    stat.lowDone  = (cnt == lowLen - 1'b1);
    stat.highDone = (cnt == highLen - 1'b1);
    stat.atMid    = (cnt == (highLen >> 1));
    stat.atChange = (cnt == CNT_W'(CHANGE_AT));
  end

endmodule

// File: rtl/sclgen_ctrl.sv
module sclgen_ctrl
  import sclgen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runReq,
  input  logic     sclIn,
  input  cntStat_t stat,
  output cntCtrl_t ctrl,
  output logic     sclOe,
  output logic     sampleStb,
  output logic     changeStb
);

  sclState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    unique case (state)
      ST_IDLE: begin
        if (runReq) begin
          stateNxt = ST_LOW;
          ctrl.clr = 1'b1;
        end
      end
      ST_LOW: begin
        if (stat.lowDone) begin
          stateNxt = ST_WAIT;
          ctrl.clr = 1'b1;
        end else begin
          ctrl.inc = 1'b1;
        end
      end
      ST_WAIT: begin
        // high timing begins only once the wired line is seen released
        if (sclIn) begin
          stateNxt  = ST_HIGH;
          ctrl.seed = 1'b1;
        end
      end
      ST_HIGH: begin
        if (!sclIn || stat.highDone) begin
          stateNxt = runReq ? ST_LOW : ST_IDLE;
          ctrl.clr = 1'b1;
        end else begin
          ctrl.inc = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign sclOe     = (state == ST_LOW);
  assign changeStb = (state == ST_LOW) && stat.atChange;
  assign sampleStb = (state == ST_HIGH) && sclIn && stat.atMid;

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import sclgen_pkg::*;
#(
  parameter int CCR_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runReq,
  input  logic [CCR_W-1:0] ccrCfg,
  input  logic             fastMode,
  input  logic             fastDuty,
  input  logic             sclIn,
  output logic             sclOe,
  output logic             sampleStb,
  output logic             changeStb
);

  cntCtrl_t cntCtrl;
  cntStat_t cntStat;

  sclgen_timer #(
    .CCR_W         (CCR_W),
    .CCR_MIN       (4),
    .CHANGE_AT     (2),
    .FAST_RATIO_EN (1'b1)
  ) timer_i (
    .clk      (clk),
    .rstN     (rstN),
    .ccrCfg   (ccrCfg),
    .fastMode (fastMode),
    .fastDuty (fastDuty),
    .ctrl     (cntCtrl),
    .stat     (cntStat)
  );

  sclgen_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .runReq    (runReq),
    .sclIn     (sclIn),
    .stat      (cntStat),
    .ctrl      (cntCtrl),
    .sclOe     (sclOe),
    .sampleStb (sampleStb),
    .changeStb (changeStb)
  );

endmodule

// File: rtl/sclgen_checker.sv
module sclgen_checker (
  input logic clk,
  input logic rstN,
  input logic runReq,
  input logic sclIn,
  input logic sclOe,
  input logic sampleStb,
  input logic changeStb
);

  // R8: sample strobe only while the line is released and reads high
  p_sample_line_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> (sclIn && !sclOe));

  // R8, R9: the two strobes never coincide
  p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && changeStb));

  // R9: change strobe falls inside a driven-low phase
  p_change_in_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    changeStb |-> sclOe);

  // R10: the line is never driven low unless running was requested
  p_drive_needs_run_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclOe) |-> $past(runReq));

  // R7: a line fall seen while released and running leads to driving low next
  p_early_pull_r7: assert property (@(posedge clk) disable iff (!rstN)
    (runReq && !sclOe && !sclIn && $past(sclIn) && !$past(sclOe)) |=> sclOe);

endmodule

bind scl_clock_gen sclgen_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .runReq    (runReq),
  .sclIn     (sclIn),
  .sclOe     (sclOe),
  .sampleStb (sampleStb),
  .changeStb (changeStb)
);

// File: tb/scl_clock_gen_tb_top.sv
module scl_clock_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runReq = 1'b0;
  logic [11:0] ccrCfg = 12'd10;
  logic        fastMode = 1'b0;
  logic        fastDuty = 1'b0;
  logic        extPull = 1'b0;
  logic        sclOe, sampleStb, changeStb;
  logic        sclLine;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign sclLine = !(sclOe || extPull);

  scl_clock_gen dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .runReq    (runReq),
    .ccrCfg    (ccrCfg),
    .fastMode  (fastMode),
    .fastDuty  (fastDuty),
    .sclIn     (sclLine),
    .sclOe     (sclOe),
    .sampleStb (sampleStb),
    .changeStb (changeStb)
  );

  function automatic int effP(int c);
    return (c < 4) ? 4 : c;
  endfunction
  function automatic int expLowF(int c, bit f, bit d);
    return (f && d) ? 16 * effP(c) : effP(c);
  endfunction
  function automatic int expHighF(int c, bit f, bit d);
    return (f && d) ? 9 * effP(c) : effP(c);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor state
  string curReq = "R2";
  int  expLow = 4, expHigh = 4;
  int  oeIdx = 0, hiIdx = 0, oeFalls = 0, sampleCnt = 0;
  bit  prevOe = 1'b0, prevLine = 1'b1, hiValid = 1'b0, chkHigh = 1'b1, monOn = 1'b0;

  always @(negedge clk) begin
    if (monOn) begin
      if (sclOe) oeIdx = prevOe ? oeIdx + 1 : 0;
      if (changeStb || (sclOe && oeIdx == 2))
        check(changeStb && sclOe && oeIdx == 2, "R9", oeIdx, 2);
      if (!sclOe && prevOe) begin
        check(oeIdx + 1 == expLow, curReq, oeIdx + 1, expLow);
        hiValid = 1'b1;
        oeFalls++;
      end
      if (sclLine) hiIdx = prevLine ? hiIdx + 1 : 0;
      if (sampleStb) sampleCnt++;
      if (sampleStb && !(hiValid && sclLine))
        check(1'b0, "R8", 1, 0);
      else if (hiValid && sclLine && (sampleStb || hiIdx == expHigh / 2))
        check(sampleStb && hiIdx == expHigh / 2, "R8", hiIdx, expHigh / 2);
      if (!sclLine && prevLine && hiValid) begin
        if (chkHigh) check(hiIdx + 1 == expHigh, curReq, hiIdx + 1, expHigh);
        hiValid = 1'b0;
      end
      prevOe   = sclOe;
      prevLine = sclLine;
    end
  end

  task automatic startRun(int c, bit f, bit d, string req);
    @(posedge clk); #1;
    ccrCfg   = 12'(c);
    fastMode = f;
    fastDuty = d;
    expLow   = expLowF(c, f, d);
    expHigh  = expHighF(c, f, d);
    curReq   = req;
    runReq   = 1'b1;
  endtask

  task automatic waitFalls(int n);
    int target = oeFalls + n;
    while (oeFalls < target) begin
      @(negedge clk); #2;
    end
  endtask

  task automatic stopRun();
    int oeSeen = 0;
    @(posedge clk); #1;
    runReq = 1'b0;
    for (int i = 0; i < expLow + expHigh + 20; i++) begin
      @(negedge clk); #2;
      if (sclOe) oeSeen++;
    end
    check(oeSeen == 0 && sclLine, "R10", oeSeen, 0);
    hiValid = 1'b0;
  endtask

  task automatic stretchOnce(int extra);
    do begin @(negedge clk); #2; end while (!changeStb);
    @(posedge clk); #1; extPull = 1'b1;
    do begin @(negedge clk); #2; end while (sclOe);
    repeat (extra) @(posedge clk);
    #1; extPull = 1'b0;
  endtask

  task automatic truncateOnce();
    int s0;
    do begin @(negedge clk); #2; end while (!(hiValid && sclLine && hiIdx == 0));
    chkHigh = 1'b0;
    s0 = sampleCnt;
    @(posedge clk); #1; extPull = 1'b1;
    @(posedge clk); #1; extPull = 1'b0;
    @(negedge clk); #2;
    check(sclOe == 1'b1, "R7", sclOe, 1);
    chkHigh = 1'b1;
    waitFalls(1);
    check(sampleCnt == s0, "R7", sampleCnt - s0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (20) @(negedge clk);
    #2;
    check(!sclOe && !sampleStb && !changeStb, "R1", sclOe, 0);
    monOn = 1'b1;

    startRun(40, 1'b0, 1'b0, "R2"); waitFalls(3); stopRun();
    startRun(5, 1'b0, 1'b1, "R2");  waitFalls(3); stopRun();
    startRun(6, 1'b1, 1'b0, "R3");  waitFalls(3); stopRun();
    startRun(4, 1'b1, 1'b1, "R4");  waitFalls(2); stopRun();
    startRun(3, 1'b1, 1'b1, "R5");  waitFalls(2); stopRun();
    startRun(1, 1'b0, 1'b0, "R5");  waitFalls(3); stopRun();

    startRun(10, 1'b0, 1'b0, "R6"); waitFalls(1);
    stretchOnce(7); waitFalls(2); stopRun();

    startRun(12, 1'b1, 1'b0, "R7"); waitFalls(1);
    truncateOnce(); waitFalls(1); stopRun();

    for (int k = 0; k < 8; k++) begin
      int  c = $urandom_range(1, 24);
      bit  f = 1'($urandom_range(0, 1));
      bit  d = 1'($urandom_range(0, 1));
      startRun(c, f, d, (f && d) ? "R4" : (f ? "R3" : "R2"));
      waitFalls(3);
      stopRun();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule